// File: doc/BRIEF.md
# Bidirectional Limit Ramp Generator

This block produces a ramp word that climbs toward a programmable ceiling or descends toward a programmable floor. A live direction input steers it. Rising and falling moves each have their own increment and their own step interval, counted in clock cycles. The ramp never passes a limit. When a step would cross a limit, the ramp lands on that limit and stays there. It moves off again when the direction flips or when the limit is moved further out. A hold input freezes the ramp mid-slope.

Three control bits are written into a shadow copy and become active only when an update strobe arrives:

- ramp enable
- persistent clear
- one-cycle autoclear

A status flag reports when the ramp rests on the limit it is heading toward.

Top module: `limit_ramp`

## Requirements
- R1: After reset the ramp word is 0, the limit flag is 0, and every active and shadow control bit is 0.
- R2: A cycle with `ctl_wr` high stores `ctl_wdata` only in the shadow copy. Bit 0 is enable, bit 1 is clear and bit 2 is autoclear. The active bits change only at an edge with `ctl_update` high, and that edge copies the shadow value as it stood before the edge. A write in the same cycle as an update is therefore not yet seen.
- R3: Suppose the update edge turns enable on. If `dir_up` is 0 one edge later, the ramp is loaded with `cfg_lower` at that edge. If `dir_up` is 1, the ramp instead takes its first rising step at that edge.
- R4: A step adds `cfg_step_up` when `dir_up` is 1 and subtracts `cfg_step_dn` when `dir_up` is 0.
- R5: Rising steps occur once every `cfg_ival_up` cycles and falling steps once every `cfg_ival_dn` cycles, where an interval of 0 counts as 1. A change of `dir_up`, a start, or the end of a clear or autoclear makes the next step fall due immediately.
- R6: A step that would reach or cross the limit it heads toward leaves the ramp exactly on that limit. The ramp then stays there while the direction is unchanged.
- R7: Suppose the ramp rests on a limit and that limit is moved further out. The ramp then resumes stepping in the same direction at its next due step.
- R8: While `hold` is 1, the ramp word and the interval count do not change. A direction change made during the hold takes effect as an immediate step on the first edge after release. Clear and autoclear override hold.
- R9: While the active clear bit is 1, the ramp equals `cfg_lower` from the edge after the update that set it. Once an update removes the clear, the ramp steps at the very next edge in the direction `dir_up` selects.
- R10: An update that sees autoclear set in the shadow copy forces the ramp to `cfg_lower` for exactly one edge, one edge after the update. Ramping then continues, even if `hold` is high at that edge.
- R11: While enable is inactive and neither clear nor autoclear is active, the ramp word does not change.
- R12: `at_limit` is 1 exactly when enable is active and the ramp equals `cfg_upper` with `dir_up` at 1, or equals `cfg_lower` with `dir_up` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lower | input | 32 | Floor of the ramp |
| cfg_upper | input | 32 | Ceiling of the ramp |
| cfg_step_up | input | 32 | Increment per rising step |
| cfg_step_dn | input | 32 | Decrement per falling step |
| cfg_ival_up | input | 16 | Cycles between rising steps (0 acts as 1) |
| cfg_ival_dn | input | 16 | Cycles between falling steps (0 acts as 1) |
| ctl_wr | input | 1 | Write strobe for the shadow control bits |
| ctl_wdata | input | 3 | Shadow value: bit0 enable, bit1 clear, bit2 autoclear |
| ctl_update | input | 1 | Copies the shadow bits into the active set |
| dir_up | input | 1 | 1 rises, 0 falls |
| hold | input | 1 | Freezes the ramp and its interval count |
| ramp_out | output | 32 | Ramp word |
| at_limit | output | 1 | Ramp rests on the limit it is heading toward |

## Verification
Two collisions are provoked on purpose. In the first, a shadow write and an update strobe are driven in the same cycle. In the second, an autoclear pulse lands while `hold` is high. The first is judged by the ramp continuing untouched for that update, then dropping to the floor one edge after a later lone update. The second is judged by the ramp leaving its frozen value for the floor on the pulse edge, staying there while hold persists, and stepping on the first edge after release.

// File: rtl/limit_ramp_pkg.sv
package limit_ramp_pkg;

   // Shadow/active control word; bit 0 enable, bit 1 clear, bit 2 autoclear
   typedef struct packed {
      logic autoclr;
      logic clear;
      logic enable;
   } ctl_bits_t;

   localparam int CTL_W = $bits(ctl_bits_t);

   // Clamp implementation variants for the accumulator
   localparam int CLAMP_DIFF = 0;
   localparam int CLAMP_WIDE = 1;

endpackage

// File: rtl/lr_ctl_latch.sv
module lr_ctl_latch
   import limit_ramp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             update,
   output logic             en_act,
   output logic             clr_act,
   output logic             acl_pulse,
   output logic             start_pulse
);

   ctl_bits_t shadow_q;
   ctl_bits_t wr_bits;

   assign wr_bits = ctl_bits_t'(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q    <= '0;
         en_act      <= 1'b0;
         clr_act     <= 1'b0;
         acl_pulse   <= 1'b0;
         start_pulse <= 1'b0;
      end else begin
         if (wr) begin
            shadow_q <= wr_bits;
         end
         acl_pulse   <= update & shadow_q.autoclr;
         start_pulse <= update & shadow_q.enable & ~en_act;
         if (update) begin
            en_act  <= shadow_q.enable;
            clr_act <= shadow_q.clear;
         end
      end
   end

endmodule

// File: rtl/lr_step_timer.sv
module lr_step_timer #(
   parameter int IVAL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              zero,
   input  logic              dir_up,
   input  logic [IVAL_W-1:0] ival_up,
   input  logic [IVAL_W-1:0] ival_dn,
   output logic              tick
);

   localparam logic [IVAL_W-1:0] IV_ONE = IVAL_W'(1);

   logic [IVAL_W-1:0] cnt_q;
   logic [IVAL_W-1:0] ival_sel;
   logic [IVAL_W-1:0] reload;

   assign ival_sel = dir_up ? ival_up : ival_dn;
   assign reload   = (ival_sel == '0) ? '0 : (ival_sel - IV_ONE);
   assign tick     = run & (restart | (cnt_q == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (zero) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= tick ? reload : (cnt_q - IV_ONE);
      end
   end

endmodule

// File: rtl/lr_accum.sv
module lr_accum
   import limit_ramp_pkg::*;
#(
   parameter int ACC_W      = 32,
   parameter int CLAMP_MODE = CLAMP_DIFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_lower,
   input  logic             step_en,
   input  logic             dir_up,
   input  logic [ACC_W-1:0] lower,
   input  logic [ACC_W-1:0] upper,
   input  logic [ACC_W-1:0] step_up,
   input  logic [ACC_W-1:0] step_dn,
   output logic [ACC_W-1:0] acc
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] rise_nxt;
   logic [ACC_W-1:0] fall_nxt;

   generate
      if (CLAMP_MODE == CLAMP_DIFF) begin : g_diff
         logic [ACC_W-1:0] room_up;
         logic [ACC_W-1:0] room_dn;
         always_comb begin
            room_up = upper - acc_q;
            room_dn = acc_q - lower;
            if ((acc_q >= upper) || (room_up <= step_up)) begin
               rise_nxt = upper;
            end else begin
               rise_nxt = acc_q + step_up;
            end
            if ((acc_q <= lower) || (room_dn <= step_dn)) begin
               fall_nxt = lower;
            end else begin
               fall_nxt = acc_q - step_dn;
            end
         end
      end else begin : g_wide
         logic [ACC_W:0] sum_up;
         logic [ACC_W:0] dif_dn;
         always_comb begin
            sum_up = {1'b0, acc_q} + {1'b0, step_up};
            dif_dn = {1'b0, acc_q} - {1'b0, step_dn};
            rise_nxt = (sum_up >= {1'b0, upper}) ? upper : sum_up[ACC_W-1:0];
            fall_nxt = (dif_dn[ACC_W] || (dif_dn[ACC_W-1:0] <= lower))
                       ? lower : dif_dn[ACC_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (load_lower) begin
         acc_q <= lower;
      end else if (step_en) begin
         acc_q <= dir_up ? rise_nxt : fall_nxt;
      end
   end

   assign acc = acc_q;

endmodule

// File: rtl/limit_ramp.sv
module limit_ramp
   import limit_ramp_pkg::*;
#(
   parameter int ACC_W      = 32,
   parameter int IVAL_W     = 16,
   parameter int CLAMP_MODE = CLAMP_DIFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  cfg_lower,
   input  logic [ACC_W-1:0]  cfg_upper,
   input  logic [ACC_W-1:0]  cfg_step_up,
   input  logic [ACC_W-1:0]  cfg_step_dn,
   input  logic [IVAL_W-1:0] cfg_ival_up,
   input  logic [IVAL_W-1:0] cfg_ival_dn,
   input  logic              ctl_wr,
   input  logic [2:0]        ctl_wdata,
   input  logic              ctl_update,
   input  logic              dir_up,
   input  logic              hold,
   output logic [ACC_W-1:0]  ramp_out,
   output logic              at_limit
);

   generate
      if (ACC_W < 8 || ACC_W > 64) begin : g_bad_acc_w
         $error("limit_ramp: ACC_W must lie in 8..64");
      end
      if (IVAL_W < 1 || IVAL_W > 32) begin : g_bad_ival_w
         $error("limit_ramp: IVAL_W must lie in 1..32");
      end
      if (CLAMP_MODE != CLAMP_DIFF && CLAMP_MODE != CLAMP_WIDE) begin : g_bad_clamp
         $error("limit_ramp: unknown CLAMP_MODE");
      end
      if (CTL_W != 3) begin : g_bad_ctl
         $error("limit_ramp: control word must be 3 bits");
      end
   endgenerate

   logic en_act;
   logic clr_act;
   logic acl_pulse;
   logic start_pulse;
   logic dir_q;
   logic restart;
   logic load_lower;
   logic run;
   logic zero;
   logic tick;

   lr_ctl_latch i_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ctl_wr),
      .wdata      (ctl_wdata),
      .update     (ctl_update),
      .en_act     (en_act),
      .clr_act    (clr_act),
      .acl_pulse  (acl_pulse),
      .start_pulse(start_pulse)
   );

   // Direction memory advances only while not held, so a change made
   // during a hold is seen as a restart on release.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
      end else if (!hold) begin
         dir_q <= dir_up;
      end
   end

   assign restart    = start_pulse | (dir_up ^ dir_q);
   assign load_lower = clr_act | acl_pulse | (start_pulse & ~dir_up);
   assign run        = en_act & ~load_lower & ~hold;
   assign zero       = load_lower | ~en_act | (start_pulse & hold);

   lr_step_timer #(
      .IVAL_W(IVAL_W)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .restart(restart),
      .zero   (zero),
      .dir_up (dir_up),
      .ival_up(cfg_ival_up),
      .ival_dn(cfg_ival_dn),
      .tick   (tick)
   );

   lr_accum #(
      .ACC_W     (ACC_W),
      .CLAMP_MODE(CLAMP_MODE)
   ) i_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_lower(load_lower),
      .step_en   (tick),
      .dir_up    (dir_up),
      .lower     (cfg_lower),
      .upper     (cfg_upper),
      .step_up   (cfg_step_up),
      .step_dn   (cfg_step_dn),
      .acc       (ramp_out)
   );

   assign at_limit = en_act & (dir_up ? (ramp_out == cfg_upper)
                                      : (ramp_out == cfg_lower));

endmodule

// File: rtl/limit_ramp_chk.sv
module limit_ramp_chk #(
   parameter int ACC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ACC_W-1:0] cfg_lower,
   input logic [ACC_W-1:0] cfg_upper,
   input logic             dir_up,
   input logic             hold,
   input logic             ctl_update,
   input logic [ACC_W-1:0] ramp_out,
   input logic             en_act,
   input logic             clr_act,
   input logic             acl_pulse,
   input logic             start_pulse
);

   AST_ACTIVE_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_update |=> ($stable(en_act) && $stable(clr_act) && !acl_pulse)); // R2

   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && en_act && !clr_act && !acl_pulse && !start_pulse) |=> $stable(ramp_out)); // R8

   AST_CLEAR_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> (ramp_out == $past(cfg_lower))); // R9

   AST_AUTOCLR_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      acl_pulse |=> (ramp_out == $past(cfg_lower))); // R10

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_act && !clr_act && !acl_pulse) |=> $stable(ramp_out)); // R11

   AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (en_act && !clr_act && !acl_pulse && dir_up && (ramp_out <= cfg_upper))
      |=> (ramp_out <= $past(cfg_upper))); // R6

   AST_NO_UNDERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      (en_act && !clr_act && !acl_pulse && !dir_up && (ramp_out >= cfg_lower))
      |=> (ramp_out >= $past(cfg_lower))); // R6

endmodule

bind limit_ramp limit_ramp_chk #(.ACC_W(ACC_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_lower  (cfg_lower),
   .cfg_upper  (cfg_upper),
   .dir_up     (dir_up),
   .hold       (hold),
   .ctl_update (ctl_update),
   .ramp_out   (ramp_out),
   .en_act     (en_act),
   .clr_act    (clr_act),
   .acl_pulse  (acl_pulse),
   .start_pulse(start_pulse)
);

// File: tb/test_limit_ramp.sv
`timescale 1ns/1ps
module test_limit_ramp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_lower = 32'd100;
   logic [31:0] cfg_upper = 32'd200;
   logic [31:0] cfg_step_up = 32'd30;
   logic [31:0] cfg_step_dn = 32'd40;
   logic [15:0] cfg_ival_up = 16'd3;
   logic [15:0] cfg_ival_dn = 16'd0;
   logic        ctl_wr = 1'b0;
   logic [2:0]  ctl_wdata = 3'b000;
   logic        ctl_update = 1'b0;
   logic        dir_up = 1'b0;
   logic        hold = 1'b0;
   logic [31:0] ramp_out;
   logic        at_limit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   limit_ramp i_limit_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_lower  (cfg_lower),
      .cfg_upper  (cfg_upper),
      .cfg_step_up(cfg_step_up),
      .cfg_step_dn(cfg_step_dn),
      .cfg_ival_up(cfg_ival_up),
      .cfg_ival_dn(cfg_ival_dn),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .ctl_update (ctl_update),
      .dir_up     (dir_up),
      .hold       (hold),
      .ramp_out   (ramp_out),
      .at_limit   (at_limit)
   );

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic t_reset;
      chk("R1 ramp after reset", ramp_out, 32'd0);
      chk("R1 flag after reset", {31'd0, at_limit}, 32'd0);
   endtask

   task automatic t_shadow_and_start_low;
      dir_up = 1'b0;
      ctl_wr = 1'b1; ctl_wdata = 3'b001;
      cyc(1);
      ctl_wr = 1'b0;
      cyc(3);
      chk("R2 write alone leaves ramp", ramp_out, 32'd0);
      ctl_update = 1'b1;
      cyc(1);
      ctl_update = 1'b0;
      chk("R3 update edge itself", ramp_out, 32'd0);
      cyc(1);
      chk("R3 start falling loads floor", ramp_out, 32'd100);
      chk("R12 flag at floor falling", {31'd0, at_limit}, 32'd1);
   endtask

   task automatic t_rise_interval;
      dir_up = 1'b1;
      cyc(1);
      chk("R4 R5 immediate rise after flip", ramp_out, 32'd130);
      chk("R12 flag mid slope", {31'd0, at_limit}, 32'd0);
      cyc(2);
      chk("R5 waits interval", ramp_out, 32'd130);
      cyc(1);
      chk("R5 step after 3 cycles", ramp_out, 32'd160);
      cyc(3);
      chk("R4 third rise", ramp_out, 32'd190);
   endtask

   task automatic t_fall_clamp;
      dir_up = 1'b0;
      cyc(1);
      chk("R4 R5 immediate fall after flip", ramp_out, 32'd150);
      cyc(2);
      chk("R6 clamps at floor", ramp_out, 32'd100);
      chk("R12 flag at floor", {31'd0, at_limit}, 32'd1);
      cyc(1);
      chk("R6 stays at floor", ramp_out, 32'd100);
   endtask

   task automatic t_floor_moved;
      cfg_lower = 32'd50;
      cyc(1);
      chk("R7 resumes after floor lowered", ramp_out, 32'd60);
      cyc(1);
      chk("R7 R6 lands on new floor", ramp_out, 32'd50);
   endtask

   task automatic t_ceiling;
      cfg_ival_up = 16'd0;
      dir_up = 1'b1;
      cyc(5);
      chk("R5 zero interval every cycle to ceiling", ramp_out, 32'd200);
      chk("R12 flag at ceiling", {31'd0, at_limit}, 32'd1);
      cyc(2);
      chk("R6 stays at ceiling", ramp_out, 32'd200);
      cfg_upper = 32'd215;
      cyc(1);
      chk("R7 resumes after ceiling raised", ramp_out, 32'd215);
   endtask

   task automatic t_hold;
      dir_up = 1'b0; hold = 1'b1;
      cyc(3);
      chk("R8 frozen during hold", ramp_out, 32'd215);
      chk("R12 flag off when heading down", {31'd0, at_limit}, 32'd0);
      hold = 1'b0;
      cyc(1);
      chk("R8 immediate fall on release", ramp_out, 32'd175);
      cyc(1);
      chk("R8 continues falling", ramp_out, 32'd135);
   endtask

   task automatic t_clear;
      ctl_wr = 1'b1; ctl_wdata = 3'b011;
      cyc(1);
      ctl_wr = 1'b0;
      chk("R2 clear write alone no effect", ramp_out, 32'd95);
      ctl_update = 1'b1;
      cyc(1);
      ctl_update = 1'b0;
      chk("R9 update edge still steps", ramp_out, 32'd55);
      cyc(1);
      chk("R9 clear forces floor", ramp_out, 32'd50);
      dir_up = 1'b1;
      cyc(2);
      chk("R9 clear persists", ramp_out, 32'd50);
      ctl_wr = 1'b1; ctl_wdata = 3'b001;
      cyc(1);
      ctl_wr = 1'b0; ctl_update = 1'b1;
      cyc(1);
      ctl_update = 1'b0;
      chk("R9 floor through release edge", ramp_out, 32'd50);
      cyc(1);
      chk("R9 ramp restarts rising", ramp_out, 32'd80);
   endtask

   task automatic t_autoclear;
      ctl_wr = 1'b1; ctl_wdata = 3'b101; ctl_update = 1'b1;
      cyc(1);
      ctl_wr = 1'b0;
      chk("R2 same-cycle write not seen", ramp_out, 32'd110);
      cyc(1);
      ctl_update = 1'b0;
      chk("R10 update edge still steps", ramp_out, 32'd140);
      cyc(1);
      chk("R10 autoclear forces floor", ramp_out, 32'd50);
      cyc(1);
      chk("R10 ramp resumes next edge", ramp_out, 32'd80);
   endtask

   task automatic t_autoclear_hold;
      hold = 1'b1; ctl_update = 1'b1;
      cyc(1);
      ctl_update = 1'b0;
      chk("R8 held at update edge", ramp_out, 32'd80);
      cyc(1);
      chk("R10 autoclear beats hold", ramp_out, 32'd50);
      cyc(1);
      chk("R10 single cycle then held", ramp_out, 32'd50);
      hold = 1'b0;
      cyc(1);
      chk("R10 steps after release", ramp_out, 32'd80);
   endtask

   task automatic t_disable;
      ctl_wr = 1'b1; ctl_wdata = 3'b000;
      cyc(1);
      ctl_wr = 1'b0; ctl_update = 1'b1;
      cyc(1);
      ctl_update = 1'b0;
      chk("R11 last step before disable", ramp_out, 32'd140);
      cyc(3);
      chk("R11 frozen while disabled", ramp_out, 32'd140);
      chk("R12 flag off while disabled", {31'd0, at_limit}, 32'd0);
   endtask

   task automatic t_start_rising;
      ctl_wr = 1'b1; ctl_wdata = 3'b001;
      cyc(1);
      ctl_wr = 1'b0; ctl_update = 1'b1;
      cyc(1);
      ctl_update = 1'b0;
      chk("R3 no move on update edge", ramp_out, 32'd140);
      cyc(1);
      chk("R3 start rising steps at once", ramp_out, 32'd170);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_shadow_and_start_low();
      t_rise_interval();
      t_fall_clamp();
      t_floor_moved();
      t_ceiling();
      t_hold();
      t_clear();
      t_autoclear();
      t_autoclear_hold();
      t_disable();
      t_start_rising();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule